// File: doc/BRIEF.md
# Signed byte load execution unit

This unit carries out the immediate-offset signed byte load for a single 32-bit instruction word. A mode input says which of three encodings the word uses. One is the 32-bit conditional form with an 8-bit split offset. The other two are 32-bit forms of the compact instruction set, one with a 12-bit offset and one with an 8-bit offset. The unit decodes the word and reads the base register through an index/value pair. It then forms the offset address and issues one byte read over a valid/ready request channel. The returned byte is sign-extended and written to the target register. When the addressing mode asks for it, a second register write puts the offset address back into the base register.

Some words belong to neighbouring instructions. Others are undefined, or valid but unpredictable. The unit reports these on three status outputs. They are valid together with a one-cycle done pulse and hold until the next accepted start. A word that is redirected or undefined causes no memory access and no register write. A failed condition input also suppresses all side effects.

Top module: `sbload_unit`

## Requirements
- R1: With enc_mode 0, a word matches only if all of these hold: bits [31:28] are not 1111, bits [27:25] are 000, bits 22 and 20 are 1, and bits [7:4] are 1101. Any other word reports undefined, with no access and no write.
- R2: In enc_mode 0, Rn is bits [19:16] and Rt is bits [15:12]. The offset is bits [11:8] joined above bits [3:0], zero-extended. Bit 24 (P) selects indexing, bit 23 (U) selects addition and bit 21 (W) is also read. Writeback happens when P is 0 or W is 1.
- R3: With enc_mode 1, bits [31:20] must be 0xF99, with Rn in bits [19:16], Rt in bits [15:12] and a 12-bit offset in bits [11:0]. The offset is always added and always indexes, and there is never a writeback.
- R4: With enc_mode 2, bits [31:20] must be 0xF91 and bit 11 must be 1, otherwise the word is undefined. Rn is bits [19:16], Rt is bits [15:12], P is bit 10, U is bit 9, W is bit 8, and the offset is bits [7:0]. Writeback equals W. P=0 with W=0 is undefined.
- R5: The redirect status is raised, with no access, in these cases: Rn=1111 in any mode; mode 0 with P=0 and W=1; mode 2 with P=1, U=1 and W=0; Rt=1111 in mode 1; Rt=1111 in mode 2 with P=1, U=0 and W=0. Redirect and undefined are never raised together.
- R6: The unpredictable status is raised, and the load still executes, in two cases: Rt=1111 in mode 0, and Rt=1111 with W=1 in mode 2.
- R7: When writeback is enabled and Rn equals Rt, both undefined and unpredictable are raised. There is no access and no write.
- R8: Exactly one byte request is made per executed load. The request stays valid with a stable address until ready is seen. The address is base ± offset when indexing, otherwise the base.
- R9: The byte is sign-extended to 32 bits and written to Rt. When writeback is enabled, the offset address is written to Rn in the next cycle.
- R10: With cond_pass low, a decodable word causes no access, no write and no status flags. Undefined and redirect words still report their flags.
- R11: Latency is counted from the clock edge that accepts start to the edge that raises done. With zero ready wait, it is 5 cycles for a load without writeback, 6 with writeback, and 2 for a suppressed word. Each cycle of ready wait adds one. The latency never depends on the loaded byte. done lasts one cycle.
- R12: enc_mode 3 is reserved and always reports undefined.
- R13: After reset, done, mem_req_valid, rf_we and all status outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept the instruction word when idle |
| insn | input | 32 | Instruction word; compact-set forms have the first halfword in [31:16] |
| enc_mode | input | 2 | 0 conditional form, 1 12-bit offset form, 2 8-bit offset form, 3 reserved |
| cond_pass | input | 1 | Condition result for this word |
| rn_idx | output | 4 | Base register read index |
| rn_val | input | 32 | Base register value for rn_idx |
| mem_req_valid | output | 1 | Byte read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_byte | input | 8 | Read data byte |
| rf_we | output | 1 | Register write enable |
| rf_widx | output | 4 | Register write index |
| rf_wdata | output | 32 | Register write data |
| done | output | 1 | One-cycle completion pulse |
| st_undef | output | 1 | Word is undefined |
| st_unpred | output | 1 | Word is unpredictable |
| st_redirect | output | 1 | Word belongs to another instruction |

## Verification
The checker assumes the memory returns exactly one response, and only after a request was accepted. It also assumes rn_val follows rn_idx within the same cycle and that start is pulsed only while the unit is idle. The bench memory model obeys all three. It raises ready only while a request is pending, and it answers with a single response pulse on the cycle after the handshake. Its register model is a combinational function of the index. The back-pressure test waits several cycles before granting ready, which exercises the request-hold property under a request that is held open.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  localparam int INSN_W = 32;
  localparam int RIDX_W = 4;
  localparam int IMM_W  = 12;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ENC_COND = 2'd0,
    ENC_WIDE = 2'd1,
    ENC_NARR = 2'd2,
    ENC_RSVD = 2'd3
  } enc_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEC  = 3'd1,
    ST_REQ  = 3'd2,
    ST_RSP  = 3'd3,
    ST_WRT  = 3'd4,
    ST_WRN  = 3'd5,
    ST_DONE = 3'd6
  } st_e;

  typedef struct packed {
    logic [RIDX_W-1:0] rn;
    logic [RIDX_W-1:0] rt;
    logic [IMM_W-1:0]  imm;
    logic              index;
    logic              add;
    logic              wback;
    logic              undef;
    logic              unpred;
    logic              redirect;
  } dec_t;
endpackage

// File: rtl/sbl_decode.sv
module sbl_decode
  import sbl_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  input  enc_e              mode,
  output dec_t              dec
);
  localparam logic [RIDX_W-1:0] REG_ALL1 = '1;

  logic match;
  logic redir;
  logic pw_bad;
  logic rt_bad;
  logic same_reg;
  logic p_b, u_b, w_b;

  always_comb begin
    match  = 1'b0;
    redir  = 1'b0;
    pw_bad = 1'b0;
    rt_bad = 1'b0;
    p_b    = insn[24];
    u_b    = insn[23];
    w_b    = insn[21];
    dec    = '0;
    dec.rn = insn[19:16];
    dec.rt = insn[15:12];
    unique case (mode)
      ENC_COND: begin
        match = (insn[31:28] != 4'hF) && (insn[27:25] == 3'b000) &&
                insn[22] && insn[20] && (insn[7:4] == 4'hD);
        dec.imm   = {4'h0, insn[11:8], insn[3:0]};
        dec.index = p_b;
        dec.add   = u_b;
        dec.wback = !p_b || w_b;
        redir     = (dec.rn == REG_ALL1) || (!p_b && w_b);
        rt_bad    = (dec.rt == REG_ALL1);
      end
      ENC_WIDE: begin
        match     = (insn[31:20] == 12'hF99);
        dec.imm   = insn[11:0];
        dec.index = 1'b1;
        dec.add   = 1'b1;
        dec.wback = 1'b0;
        redir     = (dec.rn == REG_ALL1) || (dec.rt == REG_ALL1);
      end
      ENC_NARR: begin
        p_b       = insn[10];
        u_b       = insn[9];
        w_b       = insn[8];
        match     = (insn[31:20] == 12'hF91) && insn[11];
        dec.imm   = {4'h0, insn[7:0]};
        dec.index = p_b;
        dec.add   = u_b;
        dec.wback = w_b;
        redir     = (dec.rn == REG_ALL1) || (p_b && u_b && !w_b) ||
                    ((dec.rt == REG_ALL1) && p_b && !u_b && !w_b);
        pw_bad    = !p_b && !w_b;
        rt_bad    = (dec.rt == REG_ALL1) && w_b;
      end
      default: begin
        match = 1'b0;
      end
    endcase
    same_reg     = dec.wback && (dec.rn == dec.rt);
    dec.redirect = match && redir;
    dec.undef    = !match || (!redir && (pw_bad || same_reg));
    dec.unpred   = match && !redir && !pw_bad && (rt_bad || same_reg);
  end
endmodule

// File: rtl/sbl_agu.sv
module sbl_agu
  import sbl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  input  logic              add,
  input  logic              index,
  output logic [DATA_W-1:0] offs_addr,
  output logic [DATA_W-1:0] acc_addr
);
  localparam int PAD_W = DATA_W - IMM_W;

  function automatic logic [DATA_W-1:0] step_addr(
    input logic [DATA_W-1:0] b, input logic [IMM_W-1:0] k, input logic plus);
    logic [DATA_W-1:0] kz;
    kz = {{PAD_W{1'b0}}, k};
    return plus ? (b + kz) : (b - kz);
  endfunction

  always_comb begin
    offs_addr = step_addr(base, imm, add);
    acc_addr  = index ? offs_addr : base;
  end
endmodule

// File: rtl/sbl_sext.sv
module sbl_sext
  import sbl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [BYTE_W-1:0] byte_i,
  output logic [DATA_W-1:0] word_o
);
  assign word_o[BYTE_W-1:0] = byte_i;
  for (genvar g = BYTE_W; g < DATA_W; g++) begin : g_fill
    assign word_o[g] = byte_i[BYTE_W-1];
  end
endmodule

// File: rtl/sbl_seq.sv
module sbl_seq
  import sbl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic exec_ok,
  input  logic req_ready,
  input  logic rsp_valid,
  input  logic wback,
  output st_e  state
);
  st_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start)     nxt = ST_DEC;
      ST_DEC:  nxt = exec_ok ? ST_REQ : ST_DONE;
      ST_REQ:  if (req_ready) nxt = ST_RSP;
      ST_RSP:  if (rsp_valid) nxt = ST_WRT;
      ST_WRT:  nxt = wback ? ST_WRN : ST_DONE;
      ST_WRN:  nxt = ST_DONE;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/sbload_unit.sv
module sbload_unit
  import sbl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [INSN_W-1:0] insn,
  input  logic [1:0]        enc_mode,
  input  logic              cond_pass,
  output logic [RIDX_W-1:0] rn_idx,
  input  logic [DATA_W-1:0] rn_val,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [DATA_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [BYTE_W-1:0] mem_rsp_byte,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_widx,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              done,
  output logic              st_undef,
  output logic              st_unpred,
  output logic              st_redirect
);
  st_e               state;
  logic [INSN_W-1:0] insn_q;
  logic [1:0]        mode_q;
  logic              cond_q;
  dec_t              dec;
  logic [DATA_W-1:0] offs_addr, acc_addr;
  logic [DATA_W-1:0] addr_q, wbv_q;
  logic [BYTE_W-1:0] byte_q;
  logic [DATA_W-1:0] ext_word;
  logic              wb_q;

  // named events for the checker
  logic take_start, in_dec, exec_ok;
  logic evt_skip, evt_rsp_take, evt_wr_rt, evt_wr_rn;

  assign take_start   = (state == ST_IDLE) && start;
  assign in_dec       = (state == ST_DEC);
  assign exec_ok      = !dec.undef && !dec.redirect && cond_q;
  assign evt_skip     = in_dec && !exec_ok;
  assign evt_rsp_take = (state == ST_RSP) && mem_rsp_valid;
  assign evt_wr_rt    = (state == ST_WRT);
  assign evt_wr_rn    = (state == ST_WRN);

  sbl_decode u_dec (
    .insn (insn_q),
    .mode (enc_e'(mode_q)),
    .dec  (dec)
  );

  sbl_agu #(.DATA_W(DATA_W)) u_agu (
    .base      (rn_val),
    .imm       (dec.imm),
    .add       (dec.add),
    .index     (dec.index),
    .offs_addr (offs_addr),
    .acc_addr  (acc_addr)
  );

  sbl_sext #(.DATA_W(DATA_W)) u_sext (
    .byte_i (byte_q),
    .word_o (ext_word)
  );

  sbl_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .exec_ok   (exec_ok),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .wback     (wb_q),
    .state     (state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insn_q <= '0;
      mode_q <= '0;
      cond_q <= 1'b0;
    end else if (take_start) begin
      insn_q <= insn;
      mode_q <= enc_mode;
      cond_q <= cond_pass;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wbv_q  <= '0;
      wb_q   <= 1'b0;
    end else if (in_dec) begin
      addr_q <= acc_addr;
      wbv_q  <= offs_addr;
      wb_q   <= dec.wback;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            byte_q <= '0;
    else if (evt_rsp_take) byte_q <= mem_rsp_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_undef    <= 1'b0;
      st_unpred   <= 1'b0;
      st_redirect <= 1'b0;
    end else if (take_start) begin
      st_undef    <= 1'b0;
      st_unpred   <= 1'b0;
      st_redirect <= 1'b0;
    end else if (in_dec) begin
      st_undef    <= dec.undef;
      st_redirect <= dec.redirect;
      st_unpred   <= dec.unpred && (dec.undef || dec.redirect || cond_q);
    end
  end

  assign rn_idx        = dec.rn;
  assign mem_req_valid = (state == ST_REQ);
  assign mem_addr      = addr_q;
  assign rf_we         = evt_wr_rt || evt_wr_rn;
  assign rf_widx       = evt_wr_rt ? dec.rt : dec.rn;
  assign rf_wdata      = evt_wr_rt ? ext_word : wbv_q;
  assign done          = (state == ST_DONE);
endmodule

// File: rtl/sbload_unit_chk.sv
module sbload_unit_chk
  import sbl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [DATA_W-1:0] mem_addr,
  input logic [BYTE_W-1:0] mem_rsp_byte,
  input logic              rf_we,
  input logic [RIDX_W-1:0] rf_widx,
  input logic [DATA_W-1:0] rf_wdata,
  input logic [RIDX_W-1:0] rn_idx,
  input logic              done,
  input logic              st_undef,
  input logic              st_redirect,
  input logic              evt_skip,
  input logic              evt_rsp_take,
  input logic              evt_wr_rt,
  input logic              wb_q
);
  localparam int HI_W = DATA_W - BYTE_W;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)); // R8

  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_skip |=> done && !mem_req_valid && !rf_we); // R7

  AST_SEXT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rsp_take |=> rf_we && (rf_wdata == {{HI_W{$past(mem_rsp_byte[BYTE_W-1])}}, $past(mem_rsp_byte)})); // R9

  AST_WB_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wr_rt && wb_q |=> rf_we && (rf_widx == rn_idx)); // R9

  AST_WE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !mem_req_valid); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(st_redirect && st_undef)); // R5
endmodule

bind sbload_unit sbload_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_addr      (mem_addr),
  .mem_rsp_byte  (mem_rsp_byte),
  .rf_we         (rf_we),
  .rf_widx       (rf_widx),
  .rf_wdata      (rf_wdata),
  .rn_idx        (rn_idx),
  .done          (done),
  .st_undef      (st_undef),
  .st_redirect   (st_redirect),
  .evt_skip      (evt_skip),
  .evt_rsp_take  (evt_rsp_take),
  .evt_wr_rt     (evt_wr_rt),
  .wb_q          (wb_q)
);

// File: tb/sbload_unit_test.sv
`timescale 1ns/1ps
module sbload_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 1'b0;
  logic [31:0] insn = '0;
  logic [1:0]  enc_mode = '0;
  logic        cond_pass = 1'b1;
  logic [3:0]  rn_idx;
  logic [31:0] rn_val;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_byte = '0;
  logic        rf_we;
  logic [3:0]  rf_widx;
  logic [31:0] rf_wdata;
  logic        done, st_undef, st_unpred, st_redirect;

  sbload_unit uut (.*);

  // register model: Rk holds k*0x1000 + 0x40
  assign rn_val = {16'h0, rn_idx, 12'h040};

  int nchk = 0;
  int nerr = 0;
  int ready_delay = 0;
  int req_n = 0;
  int wr_n = 0;
  int stab_err = 0;
  int wait_n = 0;
  bit waiting = 0;
  logic [31:0] held_addr = '0;
  logic [31:0] cap_addr = '0;
  logic [3:0]  wlog_idx [256];
  logic [31:0] wlog_dat [256];

  // memory and write monitor; byte at address a is a[7:0]^0xA5
  always @(negedge clk) begin
    if (rf_we) begin
      wlog_idx[wr_n % 256] = rf_widx;
      wlog_dat[wr_n % 256] = rf_wdata;
      wr_n++;
    end
    if (mem_req_ready) begin
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b1;
      mem_rsp_byte  = held_addr[7:0] ^ 8'hA5;
    end else begin
      mem_rsp_valid = 1'b0;
      if (mem_req_valid) begin
        if (!waiting) begin
          waiting   = 1'b1;
          held_addr = mem_addr;
          wait_n    = 0;
        end else if (mem_addr != held_addr) begin
          stab_err++;
        end
        if (wait_n >= ready_delay) begin
          mem_req_ready = 1'b1;
          waiting       = 1'b0;
          cap_addr      = held_addr;
          req_n++;
        end else begin
          wait_n++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  mode;
    logic        cpass;
    logic [31:0] word;
    logic [2:0]  flg;   // {redirect, undef, unpred}
    logic        acc;
    logic [31:0] addr;
    logic [3:0]  rt;
    logic [31:0] rtv;
    logic        wb;
    logic [3:0]  rn;
    logic [31:0] wbv;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b1, 32'hE1D213DC, 3'b000, 1'b1, 32'h0000207C, 4'd1,  32'hFFFFFFD9, 1'b0, 4'd0, 32'h0},
    '{2'd0, 1'b1, 32'hE17341D0, 3'b000, 1'b1, 32'h00003030, 4'd4,  32'hFFFFFF95, 1'b1, 4'd3, 32'h00003030},
    '{2'd0, 1'b1, 32'hE0D560DF, 3'b000, 1'b1, 32'h00005040, 4'd6,  32'hFFFFFFE5, 1'b1, 4'd5, 32'h0000504F},
    '{2'd0, 1'b1, 32'hE1D785D5, 3'b000, 1'b1, 32'h00007095, 4'd8,  32'h00000030, 1'b0, 4'd0, 32'h0},
    '{2'd0, 1'b1, 32'hE0F120D0, 3'b100, 1'b0, 32'h0,        4'd0,  32'h0,        1'b0, 4'd0, 32'h0},
    '{2'd0, 1'b1, 32'hE1DF10D0, 3'b100, 1'b0, 32'h0,        4'd0,  32'h0,        1'b0, 4'd0, 32'h0},
    '{2'd0, 1'b1, 32'hE1F220D1, 3'b011, 1'b0, 32'h0,        4'd0,  32'h0,        1'b0, 4'd0, 32'h0},
    '{2'd0, 1'b1, 32'hE1D2F0D4, 3'b001, 1'b1, 32'h00002044, 4'd15, 32'hFFFFFFE1, 1'b0, 4'd0, 32'h0},
    '{2'd0, 1'b1, 32'hF1D210D0, 3'b010, 1'b0, 32'h0,        4'd0,  32'h0,        1'b0, 4'd0, 32'h0},
    '{2'd0, 1'b0, 32'hE1D210D0, 3'b000, 1'b0, 32'h0,        4'd0,  32'h0,        1'b0, 4'd0, 32'h0},
    '{2'd0, 1'b1, 32'hE1D210B0, 3'b010, 1'b0, 32'h0,        4'd0,  32'h0,        1'b0, 4'd0, 32'h0},
    '{2'd1, 1'b1, 32'hF9949123, 3'b000, 1'b1, 32'h00004163, 4'd9,  32'hFFFFFFC6, 1'b0, 4'd0, 32'h0},
    '{2'd1, 1'b1, 32'hF9910FFF, 3'b000, 1'b1, 32'h0000203F, 4'd0,  32'hFFFFFF9A, 1'b0, 4'd0, 32'h0},
    '{2'd1, 1'b1, 32'hF994F010, 3'b100, 1'b0, 32'h0,        4'd0,  32'h0,        1'b0, 4'd0, 32'h0},
    '{2'd1, 1'b1, 32'hF99F1010, 3'b100, 1'b0, 32'h0,        4'd0,  32'h0,        1'b0, 4'd0, 32'h0},
    '{2'd1, 1'b1, 32'hF9933080, 3'b000, 1'b1, 32'h000030C0, 4'd3,  32'h00000065, 1'b0, 4'd0, 32'h0},
    '{2'd2, 1'b1, 32'hF9162C20, 3'b000, 1'b1, 32'h00006020, 4'd2,  32'hFFFFFF85, 1'b0, 4'd0, 32'h0},
    '{2'd2, 1'b1, 32'hF9171941, 3'b000, 1'b1, 32'h00007040, 4'd1,  32'hFFFFFFE5, 1'b1, 4'd7, 32'h00006FFF},
    '{2'd2, 1'b1, 32'hF9183FC0, 3'b000, 1'b1, 32'h00008100, 4'd3,  32'hFFFFFFA5, 1'b1, 4'd8, 32'h00008100},
    '{2'd2, 1'b1, 32'hF9162810, 3'b010, 1'b0, 32'h0,        4'd0,  32'h0,        1'b0, 4'd0, 32'h0},
    '{2'd2, 1'b1, 32'hF9162E10, 3'b100, 1'b0, 32'h0,        4'd0,  32'h0,        1'b0, 4'd0, 32'h0},
    '{2'd2, 1'b1, 32'hF916FC10, 3'b100, 1'b0, 32'h0,        4'd0,  32'h0,        1'b0, 4'd0, 32'h0},
    '{2'd2, 1'b1, 32'hF916FF01, 3'b001, 1'b1, 32'h00006041, 4'd15, 32'hFFFFFFE4, 1'b1, 4'd6, 32'h00006041},
    '{2'd2, 1'b1, 32'hF9155B01, 3'b011, 1'b0, 32'h0,        4'd0,  32'h0,        1'b0, 4'd0, 32'h0},
    '{2'd2, 1'b1, 32'hF9162410, 3'b010, 1'b0, 32'h0,        4'd0,  32'h0,        1'b0, 4'd0, 32'h0},
    '{2'd3, 1'b1, 32'hE1D213DC, 3'b010, 1'b0, 32'h0,        4'd0,  32'h0,        1'b0, 4'd0, 32'h0}
  };

  function automatic string tag_of(input vec_t v);
    if (v.flg[2])             return "R5";
    if (v.flg[1] && v.flg[0]) return "R7";
    if (v.flg[1])             return (v.mode == 2'd3) ? "R12" : (v.mode == 2'd0) ? "R1" : "R4";
    if (v.flg[0])             return "R6";
    if (!v.cpass)             return "R10";
    if (v.mode == 2'd0)       return "R2";
    if (v.mode == 2'd1)       return "R3";
    return "R4";
  endfunction

  task automatic run_vec(input vec_t v, input int dly, output int lat);
    int r0, w0, s0, nw_exp, lat_exp;
    string tg;
    tg = tag_of(v);
    r0 = req_n; w0 = wr_n; s0 = stab_err;
    ready_delay = dly;
    @(negedge clk);
    start = 1'b1; insn = v.word; enc_mode = v.mode; cond_pass = v.cpass;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk({st_redirect, st_undef, st_unpred} == v.flg, tg, {29'h0, st_redirect, st_undef, st_unpred}, {29'h0, v.flg});
    chk((req_n - r0) == int'(v.acc), "R8", req_n - r0, {31'h0, v.acc});
    chk(stab_err == s0, "R8", stab_err - s0, 0);
    if (v.acc) chk(cap_addr == v.addr, tg, cap_addr, v.addr);
    nw_exp = v.acc ? (v.wb ? 2 : 1) : 0;
    chk((wr_n - w0) == nw_exp, "R9", wr_n - w0, nw_exp);
    if (v.acc && (wr_n - w0) >= 1) begin
      chk(wlog_idx[w0 % 256] == v.rt,  "R9", {28'h0, wlog_idx[w0 % 256]}, {28'h0, v.rt});
      chk(wlog_dat[w0 % 256] == v.rtv, "R9", wlog_dat[w0 % 256], v.rtv);
    end
    if (v.acc && v.wb && (wr_n - w0) >= 2) begin
      chk(wlog_idx[(w0 + 1) % 256] == v.rn,  "R9", {28'h0, wlog_idx[(w0 + 1) % 256]}, {28'h0, v.rn});
      chk(wlog_dat[(w0 + 1) % 256] == v.wbv, "R9", wlog_dat[(w0 + 1) % 256], v.wbv);
    end
    lat_exp = v.acc ? ((v.wb ? 6 : 5) + dly) : 2;
    chk(lat == lat_exp, "R11", lat, lat_exp);
  endtask

  initial begin
    #(200000 * 5);
    nerr++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int lat_a, lat_b;
    repeat (3) @(negedge clk);
    // R13: reset state
    chk(!done && !mem_req_valid && !rf_we, "R13", {29'h0, done, mem_req_valid, rf_we}, 0);
    chk(!st_undef && !st_unpred && !st_redirect, "R13", {29'h0, st_undef, st_unpred, st_redirect}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !mem_req_valid && !rf_we, "R13", {29'h0, done, mem_req_valid, rf_we}, 0);

    for (int i = 0; i < NV; i++) begin
      int lt;
      run_vec(VEC[i], 0, lt);
    end

    // R8: back-pressure on the request, with writeback
    run_vec(VEC[1], 3, lat_a);
    // R11: same form, negative versus positive byte, equal latency
    run_vec(VEC[0], 0, lat_a);
    run_vec(VEC[3], 0, lat_b);
    chk(lat_a == lat_b, "R11", lat_a, lat_b);
    // R11: done lasts one cycle
    @(negedge clk);
    chk(!done, "R11", {31'h0, done}, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule